// File: doc/BRIEF.md
# PTP Frame Timestamp Snapshot Unit

This unit observes a 4-bit MII data stream, either the receive side or the transmit side of an Ethernet port, and records the free-running system time at the moment the start-of-frame delimiter has fully arrived. While the frame body goes past, it also picks a 48-bit source identifier and a 16-bit sequence number out of the message. These pending values become the visible snapshot only when the frame ends cleanly. A clean end means no error strobe during the frame, a good CRC status and a body long enough to contain both fields.

The snapshot holds exactly one entry. Once a frame commits, the unit raises a lock flag and ignores further frames. Software reads the time, identifier and sequence, compares the last two against the packet it received, and then sends a one-cycle clear pulse. Capture always goes into a separate pending set and moves to the visible registers in a single step. A clear that arrives in the middle of a frame therefore never yields a snapshot that mixes values from two frames.

Top module: `ptp_snap_unit`

## Requirements
- R1: After reset, `snap_locked` is 0 and the time, identifier and sequence outputs are all 0.
- R2: A delimiter is recognised when one or more nibbles of value 0x5 are followed by the nibble 0xD, all with `mii_dv` high. Any other nibble before the 0xD cancels capture until `mii_dv` falls.
- R3: The captured time equals the `sys_time` value present in the clock cycle in which the 0xD nibble is on `mii_d`.
- R4: The identifier is the 6 bytes starting at byte offset `UUID_OFS` (default 22), counted from 0 at the first byte after the delimiter. The first byte received is the most significant byte, and each byte arrives low nibble first.
- R5: The sequence field is the 2 bytes starting at byte offset `SEQ_OFS` (default 30), assembled in the same order as R4.
- R6: A frame commits at the first clock edge at which `mii_dv` is sampled low after the frame, if `frame_ok` is high in that cycle. The snapshot outputs and `snap_locked` = 1 are visible after that edge.
- R7: If `mii_err` is high in any cycle with `mii_dv` high during the frame, including the preamble, the frame does not commit.
- R8: If `frame_ok` is low in the frame-end cycle, the frame does not commit.
- R9: A frame that ends before the last nibble of both fields has arrived does not commit.
- R10: While locked, later frames change neither the snapshot outputs nor `snap_locked`.
- R11: A one-cycle `lock_clr` clears `snap_locked` at the next edge and leaves the snapshot values unchanged.
- R12: If `lock_clr` arrives in the same cycle as a committing frame end, the new frame is stored and `snap_locked` stays 1.
- R13: A frame whose delimiter arrives while locked, and which ends after a clear, commits only its own time, identifier and sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the MII nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| mii_dv | input | 1 | Data valid of the observed stream |
| mii_err | input | 1 | Error strobe of the observed stream |
| mii_d | input | 4 | Data nibble |
| frame_ok | input | 1 | CRC status, sampled in the frame-end cycle |
| sys_time | input | TIME_W | Free-running system time |
| lock_clr | input | 1 | One-cycle clear of the lock |
| snapshot_time | output | TIME_W | Locked timestamp |
| snapshot_uuid | output | 48 | Locked source identifier |
| snapshot_seq | output | 16 | Locked sequence number |
| snap_locked | output | 1 | Snapshot valid and protected |

## Verification
The assertions assume the following about the inputs. All inputs are synchronous to `clk`. `lock_clr` is a single-cycle pulse. `mii_dv` stays low for at least one cycle between frames, so that each frame shows exactly one delimiter. The stimulus drives every input on the falling edge and leaves several idle cycles after each frame. It pulses the clear for one cycle only, and it places the clear either in the frame-end cycle or in mid-body. A behavioural model built from nibble arrays and integers tracks the expected outputs on every clock.

// File: rtl/ptp_snap_pkg.sv
package ptp_snap_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_PRE, RX_BODY, RX_DROP} rx_state_e;
  localparam logic [3:0] NIB_PREAMBLE = 4'h5;
  localparam logic [3:0] NIB_DELIM    = 4'hD;
  localparam int UUID_BYTES = 6;
  localparam int SEQ_BYTES  = 2;
endpackage

// File: rtl/ptp_sfd_detect.sv
module ptp_sfd_detect
  import ptp_snap_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dv,
  input  logic [3:0]       d,
  output logic             sfd_hit,
  output logic             body_vld,
  output logic             in_body,
  output logic             frame_start,
  output logic             frame_end,
  output logic [IDX_W-1:0] nib_idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  rx_state_e state;
  logic      dv_q;

  assign sfd_hit     = dv && (state == RX_PRE) && (d == NIB_DELIM);
  assign body_vld    = dv && (state == RX_BODY);
  assign in_body     = (state == RX_BODY);
  assign frame_start = dv && !dv_q;
  assign frame_end   = dv_q && !dv;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      dv_q  <= 1'b0;
    end else begin
      dv_q <= dv;
      if (!dv) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: state <= (d == NIB_PREAMBLE) ? RX_PRE : RX_DROP;
          RX_PRE: begin
            if (d == NIB_DELIM)         state <= RX_BODY;
            else if (d != NIB_PREAMBLE) state <= RX_DROP;
          end
          default: state <= state;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_idx <= '0;
    end else if (sfd_hit) begin
      nib_idx <= '0;
    end else if (body_vld && nib_idx != IDX_MAX) begin
      nib_idx <= nib_idx + 1'b1;
    end
  end

  // one delimiter per frame: the body state follows straight after
  AST_ONE_DELIM: assert property (@(posedge clk) disable iff (rst)
    sfd_hit |=> !sfd_hit);  // R2
  AST_BODY_AFTER_DELIM: assert property (@(posedge clk) disable iff (rst)
    sfd_hit |=> (in_body && nib_idx == '0));  // R2
endmodule

// File: rtl/ptp_field_grab.sv
module ptp_field_grab #(
  parameter int IDX_W     = 8,
  parameter int OFS_BYTES = 0,
  parameter int N_BYTES   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               nib_vld,
  input  logic [IDX_W-1:0]   nib_idx,
  input  logic [3:0]         nib,
  output logic [8*N_BYTES-1:0] field,
  output logic               complete
);
  localparam int N_NIBS = 2 * N_BYTES;
  localparam int FIRST  = 2 * OFS_BYTES;
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(FIRST + N_NIBS - 1);

  for (genvar g = 0; g < N_NIBS; g++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT_I = IDX_W'(FIRST + g);
    localparam int LSB = (N_BYTES - 1 - g / 2) * 8 + (g % 2) * 4;
    always_ff @(posedge clk) begin
      if (rst) begin
        field[LSB +: 4] <= 4'h0;
      end else if (nib_vld && nib_idx == SLOT_I) begin
        field[LSB +: 4] <= nib;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      complete <= 1'b0;
    end else if (nib_vld && nib_idx == LAST_I) begin
      complete <= 1'b1;
    end
  end

  AST_COMPLETE_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(complete) |-> $past(nib_vld));  // R9
endmodule

// File: rtl/ptp_snap_store.sv
module ptp_snap_store #(
  parameter int TIME_W = 64,
  parameter int UUID_W = 48,
  parameter int SEQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic              clr,
  input  logic [TIME_W-1:0] pend_time,
  input  logic [UUID_W-1:0] pend_uuid,
  input  logic [SEQ_W-1:0]  pend_seq,
  output logic [TIME_W-1:0] snap_time,
  output logic [UUID_W-1:0] snap_uuid,
  output logic [SEQ_W-1:0]  snap_seq,
  output logic              locked
);
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_time <= '0;
      snap_uuid <= '0;
      snap_seq  <= '0;
      locked    <= 1'b0;
    end else if (commit) begin
      snap_time <= pend_time;
      snap_uuid <= pend_uuid;
      snap_seq  <= pend_seq;
      locked    <= 1'b1;
    end else if (clr) begin
      locked    <= 1'b0;
    end
  end

  AST_HOLD_WHILE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (locked && !clr) |=> (locked && $stable(snap_time) && $stable(snap_uuid) && $stable(snap_seq)));  // R10
  AST_CLEAR_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (clr && !commit) |=> (!locked && $stable(snap_seq)));  // R11
  AST_CLEAR_WITH_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (clr && commit) |=> locked);  // R12
endmodule

// File: rtl/ptp_snap_unit.sv
module ptp_snap_unit
  import ptp_snap_pkg::*;
#(
  parameter int TIME_W   = 64,
  parameter int UUID_OFS = 22,
  parameter int SEQ_OFS  = 30,
  parameter int IDX_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mii_dv,
  input  logic              mii_err,
  input  logic [3:0]        mii_d,
  input  logic              frame_ok,
  input  logic [TIME_W-1:0] sys_time,
  input  logic              lock_clr,
  output logic [TIME_W-1:0] snapshot_time,
  output logic [47:0]       snapshot_uuid,
  output logic [15:0]       snapshot_seq,
  output logic              snap_locked
);
  localparam int UUID_W = 8 * UUID_BYTES;
  localparam int SEQ_W  = 8 * SEQ_BYTES;

  logic              sfd_hit, body_vld, in_body, frame_start, frame_end;
  logic [IDX_W-1:0]  nib_idx;
  logic [TIME_W-1:0] pend_time;
  logic [UUID_W-1:0] pend_uuid;
  logic [SEQ_W-1:0]  pend_seq;
  logic              uuid_done, seq_done;
  logic              frame_bad;
  logic              commit;

  ptp_sfd_detect #(.IDX_W(IDX_W)) u_detect (
    .clk(clk), .rst(rst), .dv(mii_dv), .d(mii_d),
    .sfd_hit(sfd_hit), .body_vld(body_vld), .in_body(in_body),
    .frame_start(frame_start), .frame_end(frame_end), .nib_idx(nib_idx)
  );

  ptp_field_grab #(.IDX_W(IDX_W), .OFS_BYTES(UUID_OFS), .N_BYTES(UUID_BYTES)) u_uuid (
    .clk(clk), .rst(rst), .start(sfd_hit), .nib_vld(body_vld),
    .nib_idx(nib_idx), .nib(mii_d), .field(pend_uuid), .complete(uuid_done)
  );

  ptp_field_grab #(.IDX_W(IDX_W), .OFS_BYTES(SEQ_OFS), .N_BYTES(SEQ_BYTES)) u_seq (
    .clk(clk), .rst(rst), .start(sfd_hit), .nib_vld(body_vld),
    .nib_idx(nib_idx), .nib(mii_d), .field(pend_seq), .complete(seq_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_time <= '0;
    end else if (sfd_hit) begin
      pend_time <= sys_time;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_bad <= 1'b0;
    end else if (frame_start) begin
      frame_bad <= mii_err;
    end else if (mii_dv && mii_err) begin
      frame_bad <= 1'b1;
    end
  end

  assign commit = frame_end && in_body && !frame_bad && frame_ok &&
                  uuid_done && seq_done && (!snap_locked || lock_clr);

  ptp_snap_store #(.TIME_W(TIME_W), .UUID_W(UUID_W), .SEQ_W(SEQ_W)) u_store (
    .clk(clk), .rst(rst), .commit(commit), .clr(lock_clr),
    .pend_time(pend_time), .pend_uuid(pend_uuid), .pend_seq(pend_seq),
    .snap_time(snapshot_time), .snap_uuid(snapshot_uuid), .snap_seq(snapshot_seq),
    .locked(snap_locked)
  );

  AST_COMMIT_NEEDS_OK: assert property (@(posedge clk) disable iff (rst)
    $rose(snap_locked) |-> ($past(frame_ok) && !$past(mii_dv)));  // R8
  AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
    (frame_end && frame_bad) |=> ($stable(snapshot_time) && $stable(snapshot_seq) && $stable(snapshot_uuid)));  // R7
  AST_TIME_FROM_DELIM: assert property (@(posedge clk) disable iff (rst)
    sfd_hit |=> (pend_time == $past(sys_time)));  // R3
endmodule

// File: tb/ptp_snap_unit_tb.sv
module ptp_snap_unit_tb;
  localparam int TW = 64;
  localparam int UOFS = 22;
  localparam int SOFS = 30;
  localparam int NEED = 2 * (SOFS + 2);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mii_dv = 1'b0, mii_err = 1'b0, frame_ok = 1'b0, lock_clr = 1'b0;
  logic [3:0]    mii_d = 4'h0;
  logic [TW-1:0] sys_time = 64'h1000;
  logic [TW-1:0] snapshot_time;
  logic [47:0]   snapshot_uuid;
  logic [15:0]   snapshot_seq;
  logic          snap_locked;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ptp_snap_unit #(.TIME_W(TW), .UUID_OFS(UOFS), .SEQ_OFS(SOFS), .IDX_W(8)) u_dut (
    .clk(clk), .rst(rst), .mii_dv(mii_dv), .mii_err(mii_err), .mii_d(mii_d),
    .frame_ok(frame_ok), .sys_time(sys_time), .lock_clr(lock_clr),
    .snapshot_time(snapshot_time), .snapshot_uuid(snapshot_uuid),
    .snapshot_seq(snapshot_seq), .snap_locked(snap_locked)
  );

  always @(negedge clk) sys_time <= sys_time + 64'd7;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_state = 0, m_cnt = 0;
  bit          m_dvq = 0, m_bad = 0, m_lock = 0, m_en = 0;
  logic [TW-1:0] m_ptime = '0, m_time = '0;
  logic [47:0] m_uuid = '0;
  logic [15:0] m_seq = '0;
  logic [3:0]  m_nib [256];

  function automatic logic [7:0] m_byte(input int k);
    return {m_nib[2*k+1], m_nib[2*k]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_cnt = 0; m_dvq = 0; m_bad = 0; m_lock = 0;
      m_time = '0; m_uuid = '0; m_seq = '0; m_en = 0;
    end else begin
      m_en = 1;
      if (m_dvq && !mii_dv && m_state == 2 && !m_bad && frame_ok &&
          m_cnt >= NEED && (!m_lock || lock_clr)) begin
        m_time = m_ptime;
        m_uuid = '0;
        for (int k = 0; k < 6; k++) m_uuid = {m_uuid[39:0], m_byte(UOFS + k)};
        m_seq = {m_byte(SOFS), m_byte(SOFS + 1)};
        m_lock = 1;
      end else if (lock_clr) begin
        m_lock = 0;
      end
      if (mii_dv && !m_dvq) m_bad = mii_err;
      else if (mii_dv && mii_err) m_bad = 1;
      if (!mii_dv) m_state = 0;
      else if (m_state == 0) m_state = (mii_d == 4'h5) ? 1 : 3;
      else if (m_state == 1) begin
        if (mii_d == 4'hD) begin m_state = 2; m_ptime = sys_time; m_cnt = 0; end
        else if (mii_d != 4'h5) m_state = 3;
      end else if (m_state == 2) begin
        if (m_cnt < 256) m_nib[m_cnt] = mii_d;
        if (m_cnt < 255) m_cnt++;
      end
      m_dvq = mii_dv;
    end
  end

  always @(negedge clk) begin
    if (m_en && !rst) begin
      chk(snapshot_time == m_time, "R3 model time", snapshot_time, m_time);
      chk(snapshot_uuid == m_uuid, "R4 model uuid", 64'(snapshot_uuid), 64'(m_uuid));
      chk(snapshot_seq == m_seq, "R5 model seq", 64'(snapshot_seq), 64'(m_seq));
      chk(snap_locked == m_lock, "R6 model lock", 64'(snap_locked), 64'(m_lock));
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0]    fb [64];
  logic [TW-1:0] t_exp;

  function automatic logic [47:0] exp_uuid();
    logic [47:0] u = '0;
    for (int k = 0; k < 6; k++) u = {u[39:0], fb[UOFS + k]};
    return u;
  endfunction

  function automatic logic [15:0] exp_seq();
    return {fb[SOFS], fb[SOFS + 1]};
  endfunction

  task automatic put(input logic [3:0] v, input int n, input int err_nib, input int clr_nib);
    mii_dv = 1'b1; mii_d = v;
    mii_err = (n == err_nib);
    lock_clr = (n == clr_nib);
    @(negedge clk);
  endtask

  task automatic send(input int npre, input bit badpre, input int nbytes, input int seed,
                      input int err_nib, input bit ok, input int clr_nib, input bit clr_end);
    int n = 0;
    for (int j = 0; j < 64; j++) fb[j] = 8'((seed * 37 + j * 13 + 1) & 255);
    for (int i = 0; i < npre; i++) begin put(4'h5, n, err_nib, clr_nib); n++; end
    if (badpre) begin put(4'h7, n, err_nib, clr_nib); n++; end
    mii_dv = 1'b1; mii_d = 4'hD; mii_err = (n == err_nib); lock_clr = (n == clr_nib);
    @(posedge clk); t_exp = sys_time; @(negedge clk); n++;
    for (int j = 0; j < nbytes; j++) begin
      put(fb[j][3:0], n, err_nib, clr_nib); n++;
      put(fb[j][7:4], n, err_nib, clr_nib); n++;
    end
    mii_dv = 1'b0; mii_err = 1'b0; mii_d = 4'h0; frame_ok = ok; lock_clr = clr_end;
    @(negedge clk);
    frame_ok = 1'b0; lock_clr = 1'b0;
  endtask

  task automatic pulse_clr();
    lock_clr = 1'b1; @(negedge clk); lock_clr = 1'b0; @(negedge clk);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  logic [15:0] held_seq;
  logic [TW-1:0] held_time;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(snap_locked == 1'b0, "R1 reset lock", 64'(snap_locked), 0);
    chk(snapshot_time == '0 && snapshot_seq == '0 && snapshot_uuid == '0, "R1 reset values",
        64'(snapshot_seq), 0);

    // clean frame with a long preamble
    send(15, 0, 40, 1, -1, 1, -1, 0);
    chk(snap_locked == 1'b1, "R6 commit", 64'(snap_locked), 1);
    chk(snapshot_time == t_exp, "R3 time", snapshot_time, t_exp);
    chk(snapshot_uuid == exp_uuid(), "R4 uuid", 64'(snapshot_uuid), 64'(exp_uuid()));
    chk(snapshot_seq == exp_seq(), "R5 seq", 64'(snapshot_seq), 64'(exp_seq()));
    held_seq = snapshot_seq; held_time = snapshot_time;
    idle(3);

    // second frame while locked
    send(15, 0, 40, 2, -1, 1, -1, 0);
    chk(snapshot_seq == held_seq && snapshot_time == held_time, "R10 held", 64'(snapshot_seq), 64'(held_seq));
    chk(snap_locked == 1'b1, "R10 still locked", 64'(snap_locked), 1);
    idle(3);

    pulse_clr();
    chk(snap_locked == 1'b0, "R11 cleared", 64'(snap_locked), 0);
    chk(snapshot_seq == held_seq, "R11 values kept", 64'(snapshot_seq), 64'(held_seq));
    idle(2);

    // error in body
    send(15, 0, 40, 3, 40, 1, -1, 0);
    chk(snap_locked == 1'b0, "R7 body error", 64'(snap_locked), 0);
    idle(3);
    // error in preamble only
    send(15, 0, 40, 4, 2, 1, -1, 0);
    chk(snap_locked == 1'b0, "R7 preamble error", 64'(snap_locked), 0);
    idle(3);
    // bad CRC status
    send(15, 0, 40, 5, -1, 0, -1, 0);
    chk(snap_locked == 1'b0, "R8 bad crc", 64'(snap_locked), 0);
    idle(3);
    // too short: sequence incomplete
    send(15, 0, 31, 6, -1, 1, -1, 0);
    chk(snap_locked == 1'b0, "R9 short frame", 64'(snap_locked), 0);
    idle(3);
    // corrupt preamble nibble
    send(15, 1, 40, 7, -1, 1, -1, 0);
    chk(snap_locked == 1'b0, "R2 bad preamble", 64'(snap_locked), 0);
    chk(snapshot_seq == held_seq, "R2 no update", 64'(snapshot_seq), 64'(held_seq));
    idle(3);
    // minimal preamble: single 0x5 then 0xD
    send(1, 0, 34, 8, -1, 1, -1, 0);
    chk(snap_locked == 1'b1, "R2 short preamble commit", 64'(snap_locked), 1);
    chk(snapshot_seq == exp_seq(), "R5 seq short preamble", 64'(snapshot_seq), 64'(exp_seq()));
    idle(3);

    // clear in the frame-end cycle of a good frame
    send(15, 0, 40, 9, -1, 1, -1, 1);
    chk(snap_locked == 1'b1, "R12 lock kept", 64'(snap_locked), 1);
    chk(snapshot_seq == exp_seq(), "R12 new seq", 64'(snapshot_seq), 64'(exp_seq()));
    chk(snapshot_time == t_exp, "R12 new time", snapshot_time, t_exp);
    idle(3);

    // clear arrives mid-body of a frame that started while locked
    send(15, 0, 40, 10, -1, 1, 50, 0);
    chk(snap_locked == 1'b1, "R13 lock", 64'(snap_locked), 1);
    chk(snapshot_time == t_exp, "R13 time", snapshot_time, t_exp);
    chk(snapshot_uuid == exp_uuid(), "R13 uuid", 64'(snapshot_uuid), 64'(exp_uuid()));
    chk(snapshot_seq == exp_seq(), "R13 seq", 64'(snapshot_seq), 64'(exp_seq()));
    idle(5);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule